// File: doc/BRIEF.md
# Butterfly Multiply Round-Shift Unit

This unit is the arithmetic core of a fixed-point DCT/FFT butterfly on 64-bit integers. Each request supplies an accumulator, two multiplicands, a 6-bit shift count and an operation code. The unit forms a wrapped 64-bit product-based result, optionally adds half an LSB of the target precision, and shifts it right arithmetically by the shift count.

Three operations exist. Add-accumulate adds the product of the two multiplicands to the accumulator. Subtract-from takes that product away from the accumulator. The dual operation gives both halves of a butterfly from one request. It multiplies the sum of the accumulator and the first multiplicand by the second multiplicand, and it does the same for their difference. A full two-coefficient butterfly is built by a dual request followed by one add-accumulate on the first result and one subtract-from on the second.

Inputs are registered on the edge that samples `start`. The results are registered on the next edge, together with a single-cycle `out_valid` strobe.

Top module: `bfly_round_unit`

## Requirements
- R1: A `start` sampled high with a legal operation code produces `out_valid` high for exactly one cycle, after the second rising edge counted from the edge that sampled `start`. The results appear on the ports in that same cycle.
- R2: Operation decode uses `op_code[4:0]`, where 5'b01000 selects dual, 5'b01001 selects add-accumulate and 5'b01010 selects subtract-from. `op_code[5]` has no effect.
- R3: A `start` with any other `op_code[4:0]` never raises `out_valid`, and both result ports keep their previous values.
- R4: Add-accumulate yields acc + (mul_a * mul_b), taking the low 64 bits of the signed product.
- R5: Subtract-from yields acc - (mul_a * mul_b), taking the low 64 bits of the signed product.
- R6: Dual yields ((acc + mul_a) * mul_b) on `out_sum` and ((acc - mul_a) * mul_b) on `out_diff`, each rounded and shifted by the same count.
- R7: With a shift count of 0 the raw 64-bit value is output unchanged.
- R8: With a shift count n from 1 to 63, 2^(n-1) is added first. The sum is then shifted right by n, and the vacated upper bits are filled with bit 63 of the biased value. For example, 2^62 + 2^62 with n = 63 gives all ones.
- R9: In add-accumulate and subtract-from, `out_diff` is zero and `out_sum` carries the result.
- R10: Every intermediate sum, difference and product wraps modulo 2^64 without saturation.
- R11: While `rst_n` is low, `out_valid` is low and both result ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, sampled on the rising edge |
| op_code | input | 6 | Operation select; only bits 4:0 are decoded |
| shamt | input | 6 | Round-and-shift count n |
| acc_in | input | 64 | Accumulator operand |
| mul_a | input | 64 | First multiplicand |
| mul_b | input | 64 | Second multiplicand |
| out_sum | output | 64 | Primary result |
| out_diff | output | 64 | Secondary result (dual operation only) |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
A wrong mode latch or a bad operand register shows on the result ports in the same cycle as the `out_valid` pulse, two edges after the request. A bad bias or fill shows as an off-by-one or a wrong sign in the upper bits at that cycle. The wide-shift corner and the chained butterfly expose a stale or wrongly routed accumulator. A decode error shows either as a missing or spurious strobe, or as result ports that move on a rejected request.

// File: rtl/bfly_round_unit.sv
module bfly_round_unit #(
  parameter int W  = 64,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    op_code,
  input  logic [SW-1:0] shamt,
  input  logic [W-1:0]  acc_in,
  input  logic [W-1:0]  mul_a,
  input  logic [W-1:0]  mul_b,
  output logic [W-1:0]  out_sum,
  output logic [W-1:0]  out_diff,
  output logic          out_valid
);

  localparam logic [4:0] OP_DUAL = 5'b01000;
  localparam logic [4:0] OP_ADD  = 5'b01001;
  localparam logic [4:0] OP_SUB  = 5'b01010;
  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};

  logic          go_q, dual_q, sub_q;
  logic [SW-1:0] n_q;
  logic [W-1:0]  acc_q, a_q, b_q;

  wire is_dual = op_code[4:0] == OP_DUAL;
  wire is_add  = op_code[4:0] == OP_ADD;
  wire is_sub  = op_code[4:0] == OP_SUB;
  wire legal   = is_dual | is_add | is_sub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      dual_q <= 1'b0;
      sub_q  <= 1'b0;
      n_q    <= '0;
      acc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else begin
      go_q <= start & legal;
      if (start & legal) begin
        dual_q <= is_dual;
        sub_q  <= is_sub;
        n_q    <= shamt;
        acc_q  <= acc_in;
        a_q    <= mul_a;
        b_q    <= mul_b;
      end
    end
  end

  function automatic logic [W-1:0] round_shift(input logic [W-1:0] x, input logic [SW-1:0] n);
    logic [W-1:0] bias, biased;
    bias   = (n == '0) ? '0 : (ONE << (n - 1'b1));
    biased = x + bias;
    return W'($signed(biased) >>> n);
  endfunction

  wire [W-1:0] pre_p  = acc_q + a_q;
  wire [W-1:0] pre_m  = acc_q - a_q;
  wire [W-1:0] mop    = dual_q ? pre_p : a_q;
  wire [W-1:0] prod_1 = mop * b_q;
  wire [W-1:0] prod_2 = pre_m * b_q;
  wire [W-1:0] raw_1  = dual_q ? prod_1 : (sub_q ? acc_q - prod_1 : acc_q + prod_1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_sum   <= '0;
      out_diff  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= go_q;
      if (go_q) begin
        out_sum  <= round_shift(raw_1, n_q);
        out_diff <= dual_q ? round_shift(prod_2, n_q) : '0;
      end
    end
  end

endmodule

// File: rtl/bfly_round_unit_chk.sv
module bfly_round_unit_chk #(
  parameter int W  = 64,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [5:0]    op_code,
  input logic [SW-1:0] shamt,
  input logic [W-1:0]  acc_in,
  input logic [W-1:0]  mul_a,
  input logic [W-1:0]  mul_b,
  input logic [W-1:0]  out_sum,
  input logic [W-1:0]  out_diff,
  input logic          out_valid
);

  wire legal_in = (op_code[4:0] == 5'b01000) || (op_code[4:0] == 5'b01001) ||
                  (op_code[4:0] == 5'b01010);

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start, 2) && $past(legal_in, 2) && $past(rst_n, 2) && $past(rst_n, 1)) |-> out_valid);

  assert_nospurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(start, 2) && $past(legal_in, 2)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && $past(rst_n)) |-> ($stable(out_sum) && $stable(out_diff)));

  assert_diffzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code[4:0], 2) != 5'b01000) |-> out_diff == '0);

  assert_rawadd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code[4:0], 2) == 5'b01001 && $past(shamt, 2) == '0)
      |-> out_sum == W'($past(acc_in, 2) + $past(mul_a, 2) * $past(mul_b, 2)));

endmodule

bind bfly_round_unit bfly_round_unit_chk #(.W(W), .SW(SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .shamt(shamt),
  .acc_in(acc_in), .mul_a(mul_a), .mul_b(mul_b), .out_sum(out_sum),
  .out_diff(out_diff), .out_valid(out_valid)
);

// File: tb/bfly_round_unit_tb_top.sv
`timescale 1ns/1ps
module bfly_round_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  op_code = '0;
  logic [5:0]  shamt = '0;
  logic [63:0] acc_in = '0, mul_a = '0, mul_b = '0;
  logic [63:0] out_sum, out_diff;
  logic        out_valid;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  bfly_round_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code), .shamt(shamt),
    .acc_in(acc_in), .mul_a(mul_a), .mul_b(mul_b),
    .out_sum(out_sum), .out_diff(out_diff), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_rs(input logic [63:0] x, input int n);
    logic [63:0] b;
    if (n == 0) return x;
    b = x + (64'd1 << (n - 1));
    return $signed(b) >>> n;
  endfunction

  task automatic issue(input logic [5:0] op, input logic [5:0] n,
                       input logic [63:0] acc, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    start = 1'b1; op_code = op; shamt = n; acc_in = acc; mul_a = a; mul_b = b;
    @(negedge clk);
    start = 1'b0; acc_in = '1; mul_a = '1; mul_b = '1;
    check("R1 no early valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R1 valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic after_pulse();
    @(negedge clk);
    check("R1 single-cycle valid", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_reset();
    check("R11 valid in reset", {63'd0, out_valid}, 64'd0);
    check("R11 sum in reset", out_sum, 64'd0);
    check("R11 diff in reset", out_diff, 64'd0);
  endtask

  task automatic t_dual_vectors();
    issue(6'b001000, 6'd14, 64'ha71, 64'he6b8, 64'h2d41);
    check("R6 R8 dual sum n14", out_sum, 64'haa86);
    check("R6 R8 dual diff n14", out_diff, 64'hffffffffffff643e);
    after_pulse();
    issue(6'b001000, 6'd0, 64'ha71, 64'he6b8, 64'h2d41);
    check("R6 R7 dual sum n0", out_sum, 64'h2aa17069);
    check("R6 R7 dual diff n0", out_diff, 64'hffffffffd90f96f9);
    after_pulse();
  endtask

  task automatic t_chain();
    issue(6'b001001, 6'd14, 64'h2aa17069, 64'he6b8, 64'hd00);
    check("R4 chain add", out_sum, 64'hd963);
    check("R9 add diff zero", out_diff, 64'd0);
    after_pulse();
    issue(6'b101010, 6'd14, 64'hffffffffd90f96f9, 64'he6b8, 64'hd00);
    check("R5 R2 chain sub bit5 set", out_sum, 64'hffffffffffff3561);
    check("R9 sub diff zero", out_diff, 64'd0);
    after_pulse();
  endtask

  task automatic t_raw_modes();
    logic [63:0] acc = 64'h0123456789abcdef, a = 64'hfffffffffffffffd, b = 64'h0000000100000007;
    issue(6'b001001, 6'd0, acc, a, b);
    check("R4 R7 raw add", out_sum, acc + a * b);
    after_pulse();
    issue(6'b001010, 6'd0, acc, a, b);
    check("R5 R7 raw sub", out_sum, acc - a * b);
    after_pulse();
    issue(6'b101000, 6'd5, acc, a, b);
    check("R2 R6 dual bit5 sum", out_sum, ref_rs((acc + a) * b, 5));
    check("R2 R6 dual bit5 diff", out_diff, ref_rs((acc - a) * b, 5));
    after_pulse();
  endtask

  task automatic t_round_edges();
    issue(6'b001001, 6'd63, 64'h4000000000000000, 64'h4000000000000000, 64'd1);
    check("R8 n63 carry into sign", out_sum, 64'hffffffffffffffff);
    after_pulse();
    issue(6'b001001, 6'd1, 64'hffffffffffffffff, 64'd0, 64'd0);
    check("R8 n1 minus one", out_sum, 64'd0);
    after_pulse();
    issue(6'b001001, 6'd1, 64'hfffffffffffffffd, 64'd0, 64'd0);
    check("R8 n1 minus three", out_sum, 64'hffffffffffffffff);
    after_pulse();
    issue(6'b001001, 6'd2, 64'd6, 64'd0, 64'd0);
    check("R8 n2 half rounds up", out_sum, 64'd2);
    after_pulse();
  endtask

  task automatic t_wrap();
    issue(6'b001001, 6'd0, 64'h7fffffffffffffff, 64'd1, 64'd1);
    check("R10 add wraps", out_sum, 64'h8000000000000000);
    after_pulse();
    issue(6'b001000, 6'd0, 64'd0, 64'h8000000000000000, 64'd2);
    check("R10 dual product wraps", out_sum, 64'd0);
    check("R10 dual diff wraps", out_diff, 64'd0);
    after_pulse();
  endtask

  task automatic t_illegal();
    issue(6'b001001, 6'd0, 64'd77, 64'd0, 64'd0);
    after_pulse();
    @(negedge clk);
    start = 1'b1; op_code = 6'b001011; acc_in = 64'd5; mul_a = 64'd5; mul_b = 64'd5;
    @(negedge clk);
    start = 1'b0; op_code = 6'b000000;
    for (int i = 0; i < 4; i++) begin
      check("R3 no valid on bad op", {63'd0, out_valid}, 64'd0);
      @(negedge clk);
    end
    check("R3 sum held", out_sum, 64'd77);
    check("R3 diff held", out_diff, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_dual_vectors();
    t_chain();
    t_raw_modes();
    t_round_edges();
    t_wrap();
    t_illegal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule